// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block deserializes stereo PCM from a three-wire serial link: a bit clock, a word-select line and one data line that carries the left and right samples one after the other. It runs entirely on the bit clock as a slave. Data is sampled on the rising bit-clock edge, and word select only changes on a falling edge. The receiver turns each channel slot into a 20-bit word that is aligned to the top of the word. Every finished word appears on its channel output with a one-cycle strobe.

Two framing families are supported. In the left-aligned family the word starts at a fixed point after the word-select change: one bit period later in I2S, or at once in the zero-delay variant. The first 20 bits are kept. In the right-aligned family the word ends on the last bit before the next word-select change. The receiver recovers it from a running history of the most recent bits, so it needs no frame-length counter. A 2-bit code picks I2S or right-aligned 16, 18 or 20 bits. A separate select turns the I2S code into the zero-delay variant. Interpolation, volume and crossing into another clock domain belong to neighbouring blocks.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst_n` is low, both words read zero and both strobes are low. This holds immediately, without waiting for a clock edge.
- R2: A word-select level present since reset is not a slot boundary. The first word-select transition only arms the receiver and produces no word.
- R3: With `fmt`=00 and `msb_just`=0 (I2S), the MSB is the bit sampled on the second rising edge after a word-select transition. Word select low marks the left channel. The word for a slot is strobed after the second rising edge that follows the transition closing the slot.
- R4: With `fmt`=00 and `msb_just`=1, the MSB is the bit sampled on the first rising edge after the transition. Word select high marks the left channel. The word is strobed after the first rising edge that follows the closing transition.
- R5: With `fmt` = 01, 10 or 11, the word is the last 16, 18 or 20 bits before the closing transition, with the LSB last. Word select high marks the left channel. The word is placed in bits 19 down to 20-N and the bits below are zero. The strobe comes after the first rising edge that follows the closing transition. `msb_just` has no effect on these codes.
- R6: In the `fmt`=00 framings, bits beyond the 20th of a slot do not change the word.
- R7: In the `fmt`=00 framings, a slot shorter than 20 bits yields its bits at the top of the word, with zero below.
- R8: Each strobe lasts one bit-clock cycle. The left and right strobes are never high together. Each word holds its value until its next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | Bit clock; data sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws | input | 1 | Word select (channel framing) |
| sd | input | 1 | Serial data, MSB first |
| fmt | input | 2 | 00 I2S family, 01/10/11 right-aligned 16/18/20 bits |
| msb_just | input | 1 | With fmt 00: 1 removes the one-bit delay |
| left_word | output | 20 | Last received left word, MSB-aligned |
| left_valid | output | 1 | One-cycle strobe on a new left word |
| right_word | output | 20 | Last received right word, MSB-aligned |
| right_valid | output | 1 | One-cycle strobe on a new right word |

## Verification
Each word is due on one specific edge. In the zero-delay and right-aligned framings it updates on the first rising edge after the transition that closes the slot. In I2S it updates one rising edge later, because the receiver looks at a copy of word select delayed by one bit period. The bench drives inputs on falling edges and reads outputs on the next falling edge. The latency tests toggle word select and then require the strobe on the first or the second falling edge, depending on the framing. The vector runs only compare the words strobed after a slot has closed, and they also require that the arming transition produced nothing.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

  localparam int DEF_WORD_W = 20;

  // format code on the fmt pins; the low two right-aligned lengths step down
  typedef enum logic [1:0] {
    FMT_LEFT  = 2'b00,
    FMT_RJ_S  = 2'b01,
    FMT_RJ_M  = 2'b10,
    FMT_RJ_L  = 2'b11
  } fmt_e;

  // channel owning a slot, given the framing delay and its word-select level
  function automatic logic slot_is_left(input logic delayed, input logic slot_ws);
    return delayed ? !slot_ws : slot_ws;
  endfunction

endpackage

// File: rtl/audio_rx_framer.sv
module audio_rx_framer (
  input  logic clk,
  input  logic rst_n,
  input  logic ws,
  input  logic delay_one,
  output logic slot_edge,
  output logic closing_ws,
  output logic armed
);

  logic       ws_q1;
  logic       ws_q2;
  logic [1:0] hist_ok;
  logic       cur_ws;
  logic       hist_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q1   <= 1'b0;
      ws_q2   <= 1'b0;
      hist_ok <= 2'b00;
      armed   <= 1'b0;
    end else begin
      ws_q1   <= ws;
      ws_q2   <= ws_q1;
      hist_ok <= {hist_ok[0], 1'b1};
      if (slot_edge) armed <= 1'b1;
    end
  end

  // the one-bit framing delay is a word select seen one period late
  assign cur_ws     = delay_one ? ws_q1 : ws;
  assign closing_ws = delay_one ? ws_q2 : ws_q1;
  assign hist_valid = delay_one ? hist_ok[1] : hist_ok[0];
  assign slot_edge  = hist_valid && (cur_ws != closing_ws);

  // R2
  arm_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_edge |=> armed);

  // R2
  arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(slot_edge));

endmodule

// File: rtl/audio_rx_ljust.sv
module audio_rx_ljust #(
  parameter int WORD_W = 20,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_edge,
  input  logic              sd,
  output logic [WORD_W-1:0] word
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  wr_idx;
  logic              take_bit;

  assign wr_idx   = TOP - cnt;
  assign take_bit = (cnt < FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= FULL;
    end else if (slot_edge) begin
      acc <= {sd, {(WORD_W-1){1'b0}}};
      cnt <= CNT_W'(1);
    end else if (take_bit) begin
      acc[wr_idx] <= sd;
      cnt         <= cnt + CNT_W'(1);
    end
  end

  // completed slot is read before the boundary overwrites it
  assign word = acc;

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  // R6
  acc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_edge && !take_bit) |=> $stable(acc));

endmodule

// File: rtl/audio_rx_rjust.sv
module audio_rx_rjust #(
  parameter int WORD_W = 20,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd,
  input  logic [CNT_W-1:0]  word_len,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] hist;

  // keep the newest word_len bits and push them to the top
  function automatic logic [WORD_W-1:0] msb_align(input logic [WORD_W-1:0] v,
                                                  input logic [CNT_W-1:0]  n);
    return v << (CNT_W'(WORD_W) - n);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[WORD_W-2:0], sd};
  end

  assign word = msb_align(hist, word_len);

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist[0] == $past(sd) || !$past(rst_n));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_rx_pkg::*;
#(
  parameter int WORD_W     = DEF_WORD_W,
  parameter int SHORT_STEP = 2
) (
  input  logic              bck,
  input  logic              rst_n,
  input  logic              ws,
  input  logic              sd,
  input  logic [1:0]        fmt,
  input  logic              msb_just,
  output logic [WORD_W-1:0] left_word,
  output logic              left_valid,
  output logic [WORD_W-1:0] right_word,
  output logic              right_valid
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LEN_S = CNT_W'(WORD_W - 2*SHORT_STEP);
  localparam logic [CNT_W-1:0] LEN_M = CNT_W'(WORD_W - SHORT_STEP);
  localparam logic [CNT_W-1:0] LEN_L = CNT_W'(WORD_W);

  logic              delay_one;
  logic              rj_mode;
  logic              slot_edge;
  logic              closing_ws;
  logic              armed;
  logic              word_done;
  logic              done_left;
  logic [CNT_W-1:0]  rj_len;
  logic [WORD_W-1:0] lj_word;
  logic [WORD_W-1:0] rj_word;
  logic [WORD_W-1:0] sel_word;

  assign rj_mode   = (fmt != FMT_LEFT);
  assign delay_one = !rj_mode && !msb_just;

  always_comb begin
    case (fmt)
      FMT_RJ_S: rj_len = LEN_S;
      FMT_RJ_M: rj_len = LEN_M;
      default:  rj_len = LEN_L;
    endcase
  end

  audio_rx_framer u_framer (
    .clk        (bck),
    .rst_n      (rst_n),
    .ws         (ws),
    .delay_one  (delay_one),
    .slot_edge  (slot_edge),
    .closing_ws (closing_ws),
    .armed      (armed)
  );

  audio_rx_ljust #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ljust (
    .clk       (bck),
    .rst_n     (rst_n),
    .slot_edge (slot_edge),
    .sd        (sd),
    .word      (lj_word)
  );

  audio_rx_rjust #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rjust (
    .clk      (bck),
    .rst_n    (rst_n),
    .sd       (sd),
    .word_len (rj_len),
    .word     (rj_word)
  );

  assign word_done = slot_edge && armed;
  assign done_left = slot_is_left(delay_one, closing_ws);
  assign sel_word  = rj_mode ? rj_word : lj_word;

  logic [WORD_W-1:0] ch_word  [2];
  logic              ch_valid [2];

  // channel 0 is left, channel 1 is right
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic mine;
    assign mine = word_done && (done_left == (ch == 0));
    always_ff @(posedge bck or negedge rst_n) begin
      if (!rst_n) begin
        ch_word[ch]  <= '0;
        ch_valid[ch] <= 1'b0;
      end else begin
        ch_valid[ch] <= mine;
        if (mine) ch_word[ch] <= sel_word;
      end
    end
  end

  assign left_word   = ch_word[0];
  assign left_valid  = ch_valid[0];
  assign right_word  = ch_word[1];
  assign right_valid = ch_valid[1];

  // R8
  valid_excl_chk: assert property (@(posedge bck) disable iff (!rst_n)
    !(left_valid && right_valid));

  // R8
  left_pulse_chk: assert property (@(posedge bck) disable iff (!rst_n)
    left_valid |=> !left_valid);

  // R8
  right_pulse_chk: assert property (@(posedge bck) disable iff (!rst_n)
    right_valid |=> !right_valid);

  // R8
  left_hold_chk: assert property (@(posedge bck) disable iff (!rst_n)
    !left_valid |-> $stable(left_word));

  // R8
  right_hold_chk: assert property (@(posedge bck) disable iff (!rst_n)
    !right_valid |-> $stable(right_word));

  // R5
  short_pad_chk: assert property (@(posedge bck) disable iff (!rst_n)
    (left_valid && fmt == FMT_RJ_S) |-> left_word[2*SHORT_STEP-1:0] == '0);

  // R2
  no_word_unarmed_chk: assert property (@(posedge bck) disable iff (!rst_n)
    !armed |=> !(left_valid || right_valid));

endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic [1:0]  fmt;
    logic        msb;
    logic [5:0]  len;
    logic [19:0] lw;
    logic [19:0] rw;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 6'd32, 20'hABCDE, 20'h12345},
    '{2'b00, 1'b0, 6'd16, 20'hFFFFF, 20'h80001},
    '{2'b00, 1'b0, 6'd24, 20'h13579, 20'hECA86},
    '{2'b00, 1'b1, 6'd32, 20'h5A5A5, 20'hA5A5A},
    '{2'b00, 1'b1, 6'd24, 20'hFEDCB, 20'h00001},
    '{2'b00, 1'b1, 6'd8,  20'hAB123, 20'hFFFFF},
    '{2'b01, 1'b0, 6'd32, 20'h0BEEF, 20'h08001},
    '{2'b10, 1'b0, 6'd32, 20'h3ABCD, 20'h20001},
    '{2'b11, 1'b0, 6'd32, 20'hC3A5F, 20'h3C5A0},
    '{2'b11, 1'b0, 6'd20, 20'hFFFFF, 20'h00001},
    '{2'b01, 1'b1, 6'd16, 20'h1234A, 20'h0FFFF}
  };

  logic        bck = 1'b0;
  logic        rst_n = 1'b0;
  logic        ws = 1'b0;
  logic        sd = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        msb_just = 1'b0;
  logic [19:0] left_word;
  logic        left_valid;
  logic [19:0] right_word;
  logic        right_valid;

  int checks = 0;
  int errors = 0;
  int lcnt = 0;
  int rcnt = 0;
  logic [19:0] lgot = '0;
  logic [19:0] rgot = '0;
  int r8_bad = 0;
  logic prev_lv = 1'b0;
  logic prev_rv = 1'b0;
  logic i2s_hold = 1'b0;

  always #(CLK_PERIOD/2) bck = ~bck;

  audio_serial_rx u_dut (
    .bck         (bck),
    .rst_n       (rst_n),
    .ws          (ws),
    .sd          (sd),
    .fmt         (fmt),
    .msb_just    (msb_just),
    .left_word   (left_word),
    .left_valid  (left_valid),
    .right_word  (right_word),
    .right_valid (right_valid)
  );

  // monitor: records strobed words, watches strobe shape (R8)
  always @(negedge bck) begin
    if (!rst_n) begin
      lcnt <= 0; rcnt <= 0; prev_lv <= 1'b0; prev_rv <= 1'b0;
    end else begin
      if (left_valid) begin lcnt <= lcnt + 1; lgot <= left_word; end
      if (right_valid) begin rcnt <= rcnt + 1; rgot <= right_word; end
      if ((left_valid && right_valid) || (left_valid && prev_lv) || (right_valid && prev_rv))
        r8_bad <= r8_bad + 1;
      prev_lv <= left_valid;
      prev_rv <= right_valid;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int word_len(input logic [1:0] f);
    case (f)
      2'b01:   return 16;
      2'b10:   return 18;
      default: return 20;
    endcase
  endfunction

  // slot content MSB first in bit 31; filler ones outside the word
  function automatic logic [31:0] slot_bits(input logic [1:0] f, input int len, input logic [19:0] w);
    logic [31:0] c;
    int n;
    if (f == 2'b00) c = {w, 12'hFFF};
    else begin
      n = word_len(f);
      c = '1;
      for (int k = 0; k < n; k++) c[32 - len + k] = w[k];
    end
    return c;
  endfunction

  function automatic logic [19:0] expect_word(input logic [1:0] f, input int len, input logic [19:0] w);
    logic [19:0] e;
    int keep;
    int n;
    e = '0;
    if (f == 2'b00) begin
      keep = (len < 20) ? len : 20;
      for (int k = 0; k < keep; k++) e[19 - k] = w[19 - k];
    end else begin
      n = word_len(f);
      for (int k = 0; k < n; k++) e[20 - n + k] = w[k];
    end
    return e;
  endfunction

  task automatic drive_bit(input logic wv, input logic b);
    @(negedge bck);
    ws = wv;
    sd = b;
  endtask

  task automatic send_slot(input logic wv, input logic [31:0] c, input int len, input logic dly);
    logic b;
    for (int i = 0; i < len; i++) begin
      b = c[31 - i];
      if (dly) begin drive_bit(wv, i2s_hold); i2s_hold = b; end
      else drive_bit(wv, b);
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic m, input logic idle_ws);
    @(negedge bck);
    rst_n = 1'b0;
    fmt = f;
    msb_just = m;
    ws = idle_ws;
    sd = 1'b0;
    i2s_hold = 1'b0;
    repeat (3) @(negedge bck);
    rst_n = 1'b1;
  endtask

  task automatic run_vector(input vec_t v);
    logic dly;
    logic lft;
    string tag;
    int len;
    len = int'(v.len);
    dly = (v.fmt == 2'b00) && !v.msb;
    lft = dly ? 1'b0 : 1'b1;
    if (v.fmt != 2'b00) tag = (v.msb ? "R5 msb_just ignored" : "R5");
    else if (dly) tag = "R3";
    else tag = "R4";
    if (v.fmt == 2'b00 && len > 20) tag = {tag, "/R6"};
    if (v.fmt == 2'b00 && len < 20) tag = {tag, "/R7"};
    do_reset(v.fmt, v.msb, ~lft);
    send_slot(~lft, 32'h0, 4, dly);
    send_slot(lft, slot_bits(v.fmt, len, v.lw), len, dly);
    // R2: the arming transition yields no word
    check("R2 words before first close", 32'(lcnt + rcnt), 32'd0);
    send_slot(~lft, slot_bits(v.fmt, len, v.rw), len, dly);
    send_slot(lft, 32'h0, 6, dly);
    check({tag, " left count"}, 32'(lcnt), 32'd1);
    check({tag, " left word"}, 32'(lgot), 32'(expect_word(v.fmt, len, v.lw)));
    check({tag, " right count"}, 32'(rcnt), 32'd1);
    check({tag, " right word"}, 32'(rgot), 32'(expect_word(v.fmt, len, v.rw)));
    // R8: words held after their strobes
    check("R8 left hold", 32'(left_word), 32'(expect_word(v.fmt, len, v.lw)));
    check("R8 right hold", 32'(right_word), 32'(expect_word(v.fmt, len, v.rw)));
  endtask

  // strobe timing after the closing word-select toggle
  task automatic latency_test(input logic [1:0] f, input logic m, input int due, input string tag);
    logic lft;
    lft = ((f == 2'b00) && !m) ? 1'b0 : 1'b1;
    do_reset(f, m, ~lft);
    send_slot(~lft, 32'h0, 4, 1'b0);
    send_slot(lft, 32'hF0F0_F0F0, 24, 1'b0);
    send_slot(~lft, 32'hF0F0_F0F0, 24, 1'b0);
    send_slot(lft, 32'h0F0F_0F0F, 24, 1'b0);
    drive_bit(~lft, 1'b0);
    @(negedge bck);
    check({tag, " strobe after first edge"}, 32'(left_valid), (due == 1) ? 32'd1 : 32'd0);
    @(negedge bck);
    check({tag, " strobe after second edge"}, 32'(left_valid), (due == 2) ? 32'd1 : 32'd0);
  endtask

  initial begin
    for (int i = 0; i < NV; i++) run_vector(VECS[i]);

    latency_test(2'b00, 1'b0, 2, "R3");
    latency_test(2'b00, 1'b1, 1, "R4");
    latency_test(2'b10, 1'b0, 1, "R5");

    // R1: reset clears outputs at once, mid-stream
    run_vector(VECS[0]);
    @(negedge bck);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R1 left_word in reset", 32'(left_word), 32'd0);
    check("R1 right_word in reset", 32'(right_word), 32'd0);
    check("R1 strobes in reset", 32'({left_valid, right_valid}), 32'd0);
    @(negedge bck);
    rst_n = 1'b1;

    check("R8 strobe shape", 32'(r8_bad), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule